// File: doc/BRIEF.md
# Single-Bit Boolean Operation Unit

This unit executes the single-bit instructions of an 8-bit microcontroller core. On each clock it takes an operation code, an 8-bit bit address, the byte that holds the addressed bit, and the current carry flag. It returns the new carry, the byte address that holds the bit, the byte to write back, a write strobe, and a branch-taken flag. All results are registered, so they appear one clock after the inputs.

The carry flag acts as a one-bit accumulator. It can be cleared, set or inverted. It can be ANDed or ORed with the addressed bit or with the inverse of that bit, and it can be moved to or from the addressed bit. The addressed bit can itself be cleared, set or inverted. Two bit-test jumps are provided: a plain test, and a test that also clears the bit when it is found set. Fetching the byte and updating the program counter are handled by neighbouring logic.

Top module: `bitproc_unit`

## Requirements
- R1: While rst_n is low, and in the cycle after it, carry_o, byte_addr_o, wdata_o, wr_en_o and taken_o are all 0.
- R2: Results are registered and appear one clock after the inputs. Operation code 1 gives carry 0, code 2 gives carry 1, and code 3 gives the inverse of carry_i. None of these writes.
- R3: Code 4 clears, code 5 sets and code 6 inverts bit bit_addr_i[2:0] of byte_i. The result goes on wdata_o with wr_en_o = 1, and the other seven bits match byte_i.
- R4: Code 7 gives carry_i AND bit, code 8 gives carry_i AND NOT bit, code 9 gives carry_i OR bit, and code 10 gives carry_i OR NOT bit. None of these writes, and the stored bit is never changed.
- R5: Code 11 copies the addressed bit into carry without writing. Code 12 writes carry_i into the addressed bit with wr_en_o = 1 and leaves carry unchanged.
- R6: Code 13 sets taken_o when the addressed bit is 1 and never writes.
- R7: Code 14 sets taken_o when the addressed bit is 1. In that case it also sets wr_en_o and wdata_o is byte_i with that bit cleared. When the bit is 0, it neither writes nor branches.
- R8: A bit address below 80h selects byte address 20h + bit_addr_i[6:3]. A bit address of 80h or above selects byte address {bit_addr_i[7:3], 000}. bit_addr_i[2:0] selects the bit.
- R9: Codes 0 and 15 are idle: carry_o = carry_i, wr_en_o = 0 and taken_o = 0. Every code that does not name carry as its destination passes carry_i through. taken_o is 0 for every code except 13 and 14.
- R10: Whenever wr_en_o is 0, wdata_o equals the byte_i of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| bit_addr_i | input | 8 | Bit address |
| byte_i | input | 8 | Byte containing the addressed bit |
| carry_i | input | 1 | Current carry flag |
| carry_o | output | 1 | Updated carry flag |
| byte_addr_o | output | 8 | Byte address holding the bit |
| wdata_o | output | 8 | Byte to write back |
| wr_en_o | output | 1 | Write-back strobe |
| taken_o | output | 1 | Bit-test branch taken |

## Verification
Assertions check on every cycle the properties that hold for any operand. Clearing carry always gives 0. A write changes at most one bit of the byte. The plain bit test never writes. The test-and-clear jump writes exactly when it branches. A low bit address always maps into the 20h–2Fh byte window. The exact values of carry after the logic ops, the positions of modified bits, the upper-range address mapping and the behaviour of the idle codes are shown only by the bench. It compares these against its own model under random and directed operands.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;
    localparam int BYTE_W  = 8;
    localparam int BADDR_W = 8;
    localparam int IDX_W   = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        OP_IDLE   = 4'd0,
        OP_C_CLR  = 4'd1,
        OP_C_SET  = 4'd2,
        OP_C_INV  = 4'd3,
        OP_B_CLR  = 4'd4,
        OP_B_SET  = 4'd5,
        OP_B_INV  = 4'd6,
        OP_AND_B  = 4'd7,
        OP_AND_NB = 4'd8,
        OP_OR_B   = 4'd9,
        OP_OR_NB  = 4'd10,
        OP_B2C    = 4'd11,
        OP_C2B    = 4'd12,
        OP_TST    = 4'd13,
        OP_TSTCLR = 4'd14,
        OP_SPARE  = 4'd15
    } bop_e;

    typedef struct packed {
        logic              carry;
        logic [BADDR_W-1:0] byte_addr;
        logic [BYTE_W-1:0]  wdata;
        logic              wr_en;
        logic              taken;
    } bres_t;
endpackage

// File: rtl/bitproc_addr_map.sv
module bitproc_addr_map
    import bitproc_pkg::*;
#(
    parameter logic [BADDR_W-1:0] RAM_BASE = 8'h20
) (
    input  logic [BADDR_W-1:0] bit_addr_i,
    output logic [BADDR_W-1:0] byte_addr_o,
    output logic [IDX_W-1:0]   bit_idx_o
);
    localparam int ROW_W = BADDR_W - 1 - IDX_W;

    always_comb begin
        bit_idx_o = bit_addr_i[IDX_W-1:0];
        if (bit_addr_i[BADDR_W-1]) begin
            byte_addr_o = {bit_addr_i[BADDR_W-1:IDX_W], {IDX_W{1'b0}}};
        end else begin
            byte_addr_o = RAM_BASE
                        + {{(BADDR_W-ROW_W){1'b0}}, bit_addr_i[BADDR_W-2:IDX_W]};
        end
    end
endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
    import bitproc_pkg::*;
(
    input  bop_e              op_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic              carry_i,
    output logic              carry_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              wr_en_o,
    output logic              taken_o
);
    logic [BYTE_W-1:0] sel_mask;
    logic              cur_bit;
    logic              new_bit;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
        assign sel_mask[i] = (bit_idx_i == IDX_W'(i));
    end

    assign cur_bit = |(byte_i & sel_mask);

    always_comb begin
        carry_o = carry_i;
        new_bit = cur_bit;
        wr_en_o = 1'b0;
        taken_o = 1'b0;
        unique case (op_i)
            OP_C_CLR:  carry_o = 1'b0;
            OP_C_SET:  carry_o = 1'b1;
            OP_C_INV:  carry_o = ~carry_i;
            OP_B_CLR:  begin new_bit = 1'b0;     wr_en_o = 1'b1; end
            OP_B_SET:  begin new_bit = 1'b1;     wr_en_o = 1'b1; end
            OP_B_INV:  begin new_bit = ~cur_bit; wr_en_o = 1'b1; end
            OP_AND_B:  carry_o = carry_i & cur_bit;
            OP_AND_NB: carry_o = carry_i & ~cur_bit;
            OP_OR_B:   carry_o = carry_i | cur_bit;
            OP_OR_NB:  carry_o = carry_i | ~cur_bit;
            OP_B2C:    carry_o = cur_bit;
            OP_C2B:    begin new_bit = carry_i;  wr_en_o = 1'b1; end
            OP_TST:    taken_o = cur_bit;
            OP_TSTCLR: begin
                taken_o = cur_bit;
                wr_en_o = cur_bit;
                new_bit = 1'b0;
            end
            default: ;
        endcase
        wdata_o = new_bit ? (byte_i | sel_mask) : (byte_i & ~sel_mask);
        if (!wr_en_o) wdata_o = byte_i;
    end
endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
    import bitproc_pkg::*;
#(
    parameter logic [7:0] RAM_BASE = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] op_i,
    input  logic [7:0] bit_addr_i,
    input  logic [7:0] byte_i,
    input  logic       carry_i,
    output logic       carry_o,
    output logic [7:0] byte_addr_o,
    output logic [7:0] wdata_o,
    output logic       wr_en_o,
    output logic       taken_o
);
    bres_t             res_d, res_q;
    logic [IDX_W-1:0]  idx;
    logic [BADDR_W-1:0] baddr;
    logic              c_n, we_n, tk_n;
    logic [BYTE_W-1:0] wd_n;

    bitproc_addr_map #(.RAM_BASE(RAM_BASE)) u_map (
        .bit_addr_i (bit_addr_i),
        .byte_addr_o(baddr),
        .bit_idx_o  (idx)
    );

    bitproc_alu u_alu (
        .op_i     (bop_e'(op_i)),
        .byte_i   (byte_i),
        .bit_idx_i(idx),
        .carry_i  (carry_i),
        .carry_o  (c_n),
        .wdata_o  (wd_n),
        .wr_en_o  (we_n),
        .taken_o  (tk_n)
    );

    always_comb begin
        res_d.carry     = c_n;
        res_d.byte_addr = baddr;
        res_d.wdata     = wd_n;
        res_d.wr_en     = we_n;
        res_d.taken     = tk_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign carry_o     = res_q.carry;
    assign byte_addr_o = res_q.byte_addr;
    assign wdata_o     = res_q.wdata;
    assign wr_en_o     = res_q.wr_en;
    assign taken_o     = res_q.taken;

    p_carry_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1) |=> !carry_o);

    p_single_bit_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {4'd4, 4'd5, 4'd6, 4'd12, 4'd14})
        |=> ($countones(wdata_o ^ $past(byte_i)) <= 1));

    p_test_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd13) |=> !wr_en_o);

    p_testclr_write_iff_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd14) |=> (wr_en_o == taken_o));

    p_low_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_addr_i[7] |=> (byte_addr_o[7:4] == RAM_BASE[7:4]));
endmodule

// File: tb/bitproc_unit_test.sv
module bitproc_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] bit_addr_i = '0;
    logic [7:0] byte_i = '0;
    logic       carry_i = 1'b0;
    logic       carry_o, wr_en_o, taken_o;
    logic [7:0] byte_addr_o, wdata_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bitproc_unit uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .bit_addr_i(bit_addr_i),
        .byte_i(byte_i), .carry_i(carry_i), .carry_o(carry_o),
        .byte_addr_o(byte_addr_o), .wdata_o(wdata_o),
        .wr_en_o(wr_en_o), .taken_o(taken_o)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_addr(input logic [7:0] a);
        if (a >= 8'h80) return a & 8'hF8;
        return 8'h20 + 8'(a / 8 % 16);
    endfunction

    function automatic logic m_carry(input logic [3:0] op, input logic b, input logic c);
        case (op)
            4'd1:  return 1'b0;
            4'd2:  return 1'b1;
            4'd3:  return !c;
            4'd7:  return c && b;
            4'd8:  return c && !b;
            4'd9:  return c || b;
            4'd10: return c || !b;
            4'd11: return b;
            default: return c;
        endcase
    endfunction

    function automatic logic m_we(input logic [3:0] op, input logic b);
        return (op >= 4'd4 && op <= 4'd6) || op == 4'd12 || (op == 4'd14 && b);
    endfunction

    function automatic logic [7:0] m_wdata(input logic [3:0] op, input logic [7:0] d,
                                           input logic [2:0] k, input logic c);
        logic [7:0] r = d;
        logic b = d[k];
        case (op)
            4'd4:  r[k] = 1'b0;
            4'd5:  r[k] = 1'b1;
            4'd6:  r[k] = !b;
            4'd12: r[k] = c;
            4'd14: r[k] = 1'b0;
            default: ;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd1, 4'd2, 4'd3:            return "R2";
            4'd4, 4'd5, 4'd6:            return "R3";
            4'd7, 4'd8, 4'd9, 4'd10:     return "R4";
            4'd11, 4'd12:                return "R5";
            4'd13:                       return "R6";
            4'd14:                       return "R7";
            default:                     return "R9";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] d, input logic c);
        logic b = d[a[2:0]];
        string t = tag_of(op);
        op_i = op; bit_addr_i = a; byte_i = d; carry_i = c;
        @(negedge clk);
        check(t, "carry", {7'd0, carry_o}, {7'd0, m_carry(op, b, c)});
        check("R8", "byte_addr", byte_addr_o, m_addr(a));
        check(t, "wr_en", {7'd0, wr_en_o}, {7'd0, m_we(op, b)});
        check(t, "taken", {7'd0, taken_o}, {7'd0, (op == 4'd13 || op == 4'd14) && b});
        if (m_we(op, b)) check(t, "wdata", wdata_o, m_wdata(op, d, a[2:0], c));
        else             check("R10", "wdata", wdata_o, d);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", "carry", {7'd0, carry_o}, 8'd0);
        check("R1", "wdata", wdata_o, 8'd0);
        check("R1", "wr_en", {7'd0, wr_en_o}, 8'd0);
        check("R1", "taken", {7'd0, taken_o}, 8'd0);
        check("R1", "byte_addr", byte_addr_o, 8'd0);
        rst_n = 1'b1;
        // directed corner cases
        run_op(4'd14, 8'h2B, 8'hFF, 1'b0);   // R7 bit set: clear + branch
        run_op(4'd14, 8'h2B, 8'hF7, 1'b1);   // R7 bit clear: nothing
        run_op(4'd13, 8'h07, 8'h80, 1'b0);   // R6
        run_op(4'd8,  8'h7F, 8'h00, 1'b1);   // R4 inverted operand
        run_op(4'd10, 8'h80, 8'h01, 1'b0);   // R4
        run_op(4'd12, 8'hFF, 8'h00, 1'b1);   // R5 + R8 top address
        run_op(4'd11, 8'h00, 8'h01, 1'b0);   // R5 + R8 bottom address
        run_op(4'd15, 8'h55, 8'hA5, 1'b1);   // R9 spare code
        run_op(4'd0,  8'hD3, 8'h3C, 1'b1);   // R9 idle code
        run_op(4'd3,  8'h10, 8'h00, 1'b1);   // R2
        run_op(4'd6,  8'hE5, 8'h5A, 1'b0);   // R3
        for (int n = 0; n < 3000; n++) begin
            run_op(4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule